// File: doc/BRIEF.md
# Programmable Serial Baud Tick Generator

This block derives the timing strobes for a serial port from the system clock. An 8-bit period value X, written through a strobe, sets a free-running down-counter that produces one base tick every X+1 clocks. The base tick is the oversample strobe. A prescaler then divides it by 64 (asynchronous, low speed), 16 (asynchronous, high speed) or 4 (synchronous) to form the bit-rate strobe. In synchronous mode the speed input has no effect.

The block also cleans up the raw receive pin. It takes three samples on consecutive oversample ticks around the centre of each bit and registers their majority as the received level, which then holds for one bit time. A write to the period value restarts both counters at once, so the new rate takes effect without waiting out the old period. A change of mode restarts the prescaler.

Top module: `baud_tick_gen`

## Requirements
- R1: A synchronous active-high reset clears the period value and both counters to zero and sets rx_level to 1. With the period at zero, os_tick is high in every cycle after reset.
- R2: When no write occurs, os_tick is a one-cycle pulse repeating every X+1 clocks, where X is the stored period value. For X = 0 it is high in every cycle.
- R3: In asynchronous low-speed mode (sync_mode=0, high_speed=0) bit_tick repeats every 64·(X+1) clocks. For X = 25 this is 1664 clocks, which gives 9615 baud from a 16 MHz clock.
- R4: In asynchronous high-speed mode (sync_mode=0, high_speed=1) bit_tick repeats every 16·(X+1) clocks.
- R5: In synchronous mode (sync_mode=1) bit_tick repeats every 4·(X+1) clocks, whatever the value of high_speed.
- R6: A write (period_we high in cycle t) stores period_wdata and restarts the timer and the prescaler. os_tick is low in cycle t, the next os_tick falls in cycle t+1+X, and the first bit_tick falls in cycle t+D·(X+1), where D is the divisor for the current mode.
- R7: A change of the selected divisor (a change of sync_mode, or of high_speed while asynchronous) in cycle t clears the prescaler. No bit_tick is produced in cycle t, and the next bit_tick is the D-th os_tick after cycle t.
- R8: Number the os_ticks since the last bit_tick or restart from 0, and let M = D/2. rx_pin is sampled on ticks M-1, M and M+1. On tick M+1, rx_level takes the majority of the three samples. At all other times it holds its value.
- R9: bit_tick is only ever high in a cycle where os_tick is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_we | input | 1 | Write strobe for the period value |
| period_wdata | input | 8 | New period value X |
| sync_mode | input | 1 | 1 = synchronous (divide by 4), 0 = asynchronous |
| high_speed | input | 1 | Asynchronous divisor select: 1 = 16, 0 = 64 |
| rx_pin | input | 1 | Raw receive line |
| os_tick | output | 1 | Oversample strobe, one pulse every X+1 clocks |
| bit_tick | output | 1 | Bit-rate strobe |
| rx_level | output | 1 | Majority-voted receive level |

## Verification
The assertions take the mode and speed inputs and the write strobe to be free of X after reset. They also assume that a write and a mode change may coincide, with both treated as one restart. No other input constraint is needed, since every input combination is legal on every cycle. The stimulus keeps the random period values small (0 to 9), so that many bit periods pass in each segment. It changes modes and writes the period at random cycle offsets, which include the cycles where an os_tick or bit_tick would fall. A few directed runs cover X = 0, X = 25 in low-speed mode, and toggling high_speed in synchronous mode.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  typedef enum logic [1:0] {
    SEL_SYNC = 2'd0,
    SEL_FAST = 2'd1,
    SEL_SLOW = 2'd2
  } div_sel_e;

  // Divisor choice: the speed bit only matters when asynchronous.
  function automatic div_sel_e pick_sel(input logic sync_m, input logic fast);
    if (sync_m) return SEL_SYNC;
    else if (fast) return SEL_FAST;
    else return SEL_SLOW;
  endfunction

  function automatic int unsigned sel_div(input div_sel_e s, input int unsigned sy_div,
                                          input int unsigned hs_div, input int unsigned ls_div);
    case (s)
      SEL_SYNC: return sy_div;
      SEL_FAST: return hs_div;
      default:  return ls_div;
    endcase
  endfunction

  function automatic logic vote3(input logic [2:0] s);
    return ($countones(s) >= 2);
  endfunction

endpackage

// File: rtl/bt_period_timer.sv
module bt_period_timer #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             period_we,
  input  logic [PER_W-1:0] period_wdata,
  output logic             os_tick
);
  logic [PER_W-1:0] period_q;
  logic [PER_W-1:0] cnt_q;
  logic             at_term;

  assign at_term = (cnt_q == '0);
  assign os_tick = at_term && !period_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      cnt_q    <= '0;
    end else if (period_we) begin
      period_q <= period_wdata;
      cnt_q    <= period_wdata;
    end else if (at_term) begin
      cnt_q <= period_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R6: a write reloads the timer with the written value
  a_r6_write_reload: assert property (@(posedge clk) disable iff (rst)
    period_we |=> (cnt_q == $past(period_wdata)));

  // R2: zero period ticks every cycle that has no write
  a_r2_zero_period: assert property (@(posedge clk) disable iff (rst)
    (period_q == '0 && !period_we) |-> os_tick);

  // R2: after a tick the timer restarts from the stored period
  a_r2_tick_reload: assert property (@(posedge clk) disable iff (rst)
    (os_tick && !period_we) |=> (period_we || cnt_q == $past(period_q)));

endmodule

// File: rtl/bt_prescaler.sv
module bt_prescaler
  import baud_tick_pkg::*;
#(
  parameter int SY_DIV = 4,
  parameter int HS_DIV = 16,
  parameter int LS_DIV = 64,
  localparam int PRE_W = $clog2(LS_DIV)
) (
  input  logic clk,
  input  logic rst,
  input  logic period_we,
  input  logic sync_mode,
  input  logic high_speed,
  input  logic os_tick,
  output logic restart,
  output logic bit_tick,
  output logic samp_shift,
  output logic vote_ev
);
  div_sel_e         sel_now, sel_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim, mid;
  logic             live_tick;

  always_comb begin
    sel_now = pick_sel(sync_mode, high_speed);
    lim     = PRE_W'(sel_div(sel_now, SY_DIV, HS_DIV, LS_DIV) - 1);
    mid     = PRE_W'(sel_div(sel_now, SY_DIV, HS_DIV, LS_DIV) / 2);
  end

  assign restart    = period_we || (sel_now != sel_q);
  assign live_tick  = os_tick && !restart;
  assign bit_tick   = live_tick && (pre_q == lim);
  assign samp_shift = live_tick && ((pre_q == mid - 1'b1) || (pre_q == mid));
  assign vote_ev    = live_tick && (pre_q == mid + 1'b1);

  always_ff @(posedge clk) begin
    sel_q <= sel_now;
    if (rst || restart) pre_q <= '0;
    else if (os_tick) pre_q <= (pre_q == lim) ? '0 : pre_q + 1'b1;
  end

  // R9: the bit strobe always coincides with an oversample strobe
  a_r9_bit_on_os: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> os_tick);

  // R7: a restart clears the prescaler
  a_r7_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> (pre_q == '0));

  // R7: no bit strobe in a restart cycle
  a_r7_no_bit_on_restart: assert property (@(posedge clk) disable iff (rst)
    restart |-> !bit_tick);

  // R3: the prescaler never passes the limit for the current divisor
  a_r3_pre_in_range: assert property (@(posedge clk) disable iff (rst)
    !restart |-> (pre_q <= lim));

endmodule

// File: rtl/bt_rx_vote.sv
module bt_rx_vote
  import baud_tick_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic samp_shift,
  input  logic vote_ev,
  input  logic rx_pin,
  output logic rx_level
);
  logic [1:0] samp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q   <= 2'b11;
      rx_level <= 1'b1;
    end else begin
      if (samp_shift) samp_q <= {samp_q[0], rx_pin};
      if (vote_ev) rx_level <= vote3({samp_q, rx_pin});
    end
  end

  // R8: the level only moves at a vote
  a_r8_level_held: assert property (@(posedge clk) disable iff (rst)
    !vote_ev |=> $stable(rx_level));

  // R8: sampling and voting never share a tick
  a_r8_disjoint_events: assert property (@(posedge clk) disable iff (rst)
    !(samp_shift && vote_ev));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int PER_W  = 8,
  parameter int SY_DIV = 4,
  parameter int HS_DIV = 16,
  parameter int LS_DIV = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             period_we,
  input  logic [PER_W-1:0] period_wdata,
  input  logic             sync_mode,
  input  logic             high_speed,
  input  logic             rx_pin,
  output logic             os_tick,
  output logic             bit_tick,
  output logic             rx_level
);
  logic restart;
  logic samp_shift;
  logic vote_ev;

  bt_period_timer #(.PER_W(PER_W)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .period_we    (period_we),
    .period_wdata (period_wdata),
    .os_tick      (os_tick)
  );

  bt_prescaler #(.SY_DIV(SY_DIV), .HS_DIV(HS_DIV), .LS_DIV(LS_DIV)) u_pre (
    .clk        (clk),
    .rst        (rst),
    .period_we  (period_we),
    .sync_mode  (sync_mode),
    .high_speed (high_speed),
    .os_tick    (os_tick),
    .restart    (restart),
    .bit_tick   (bit_tick),
    .samp_shift (samp_shift),
    .vote_ev    (vote_ev)
  );

  bt_rx_vote u_vote (
    .clk        (clk),
    .rst        (rst),
    .samp_shift (samp_shift),
    .vote_ev    (vote_ev),
    .rx_pin     (rx_pin),
    .rx_level   (rx_level)
  );

  // R6: no oversample strobe in a write cycle
  a_r6_quiet_on_write: assert property (@(posedge clk) disable iff (rst)
    period_we |-> !os_tick);

  // R8: a vote never lands in a restart cycle
  a_r8_vote_not_restart: assert property (@(posedge clk) disable iff (rst)
    restart |-> !vote_ev);

endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       period_we = 1'b0;
  logic [7:0] period_wdata = 8'd0;
  logic       sync_mode = 1'b0;
  logic       high_speed = 1'b0;
  logic       rx_pin = 1'b1;
  logic       os_tick, bit_tick, rx_level;

  int tests = 0;
  int fails = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  baud_tick_gen u_dut (
    .clk(clk), .rst(rst), .period_we(period_we), .period_wdata(period_wdata),
    .sync_mode(sync_mode), .high_speed(high_speed), .rx_pin(rx_pin),
    .os_tick(os_tick), .bit_tick(bit_tick), .rx_level(rx_level)
  );

  function automatic int exp_div(input logic s, input logic h);
    if (s) return 4;
    return h ? 16 : 64;
  endfunction

  function automatic logic maj(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Reference model: cycles since timer restart, ticks since prescaler restart.
  int   m_per = 0, m_since = 0, m_nt = 0, m_div_q = 64;
  logic m_s1 = 1'b1, m_s0 = 1'b1, m_lvl = 1'b1;

  function automatic logic e_os();
    return !period_we && (((m_since + 1) % (m_per + 1)) == 0);
  endfunction
  function automatic logic e_restart();
    return period_we || (exp_div(sync_mode, high_speed) != m_div_q);
  endfunction

  always @(posedge clk) begin
    int d, pos;
    logic os, rs;
    d = exp_div(sync_mode, high_speed);
    os = e_os();
    rs = e_restart();
    pos = m_nt % d;
    if (rst) begin
      m_per = 0; m_since = 0; m_nt = 0; m_s1 = 1; m_s0 = 1; m_lvl = 1;
    end else begin
      if (os && !rs && (pos == d/2 - 1 || pos == d/2)) begin
        m_s1 = m_s0; m_s0 = rx_pin;
      end else if (os && !rs && pos == d/2 + 1) begin
        m_lvl = maj(m_s1, m_s0, rx_pin);
      end
      if (period_we) begin
        m_per = int'(period_wdata); m_since = 0;
      end else m_since = m_since + 1;
      if (rs) m_nt = 0;
      else if (os) m_nt = m_nt + 1;
    end
    m_div_q = d;
  end

  always @(negedge clk) begin
    if (chk_en && !rst) begin
      logic eo, eb;
      int d;
      d = exp_div(sync_mode, high_speed);
      eo = e_os();
      eb = eo && !e_restart() && ((m_nt % d) == d - 1);
      tests++;
      if (os_tick !== eo || bit_tick !== eb || rx_level !== m_lvl) begin
        fails++;
        $display("FAIL R2/R5/R6/R7/R8 model: os=%b/%b bit=%b/%b lvl=%b/%b (actual/expected)",
                 os_tick, eo, bit_tick, eb, rx_level, m_lvl);
      end
      if (bit_tick && !os_tick) begin
        fails++;
        $display("FAIL R9 bit_tick=%b os_tick=%b expected os_tick=1", bit_tick, os_tick);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int x);
    @(posedge clk); #1;
    period_we = 1'b1; period_wdata = 8'(x);
    @(posedge clk); #1;
    period_we = 1'b0;
  endtask

  // Cycles between two successive bit_ticks.
  task automatic bit_gap(output int gap);
    gap = 0;
    do @(negedge clk); while (!bit_tick);
    do begin @(negedge clk); gap++; end while (!bit_tick && gap < 20000);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int g, n, wcyc, first;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rx_level in reset", int'(rx_level), 1);
    check("R1 os_tick with zero period", int'(os_tick), 1);
    @(posedge clk); #1; rst = 1'b0;
    chk_en = 1'b1;
    n = 0;
    repeat (10) begin @(negedge clk); n += int'(os_tick); end
    check("R1 R2 os_tick every cycle after reset", n, 10);

    // R3: X=25 low speed -> 1664 clocks, 9615 baud at 16 MHz
    wr(25);
    bit_gap(g);
    check("R3 low-speed gap X=25", g, 1664);
    check("R3 baud at 16 MHz", 16000000 / g, 9615);

    // R4: high speed
    high_speed = 1'b1; wr(3);
    bit_gap(g);
    check("R4 high-speed gap X=3", g, 64);

    // R5: synchronous, speed bit ignored
    sync_mode = 1'b1; high_speed = 1'b0; wr(5);
    bit_gap(g);
    check("R5 sync gap hs=0", g, 24);
    @(posedge clk); #1; high_speed = 1'b1;
    bit_gap(g);
    check("R5 sync gap hs=1", g, 24);

    // R2: os spacing with X=4, R6: first os_tick and first bit_tick after write
    @(posedge clk); #1; period_we = 1'b1; period_wdata = 8'd4;
    @(negedge clk);
    check("R6 os_tick low in write cycle", int'(os_tick), 0);
    @(posedge clk); #1; period_we = 1'b0;
    wcyc = 1; first = -1;
    while (first < 0 && wcyc < 100) begin
      @(negedge clk);
      if (os_tick) first = wcyc;
      else wcyc++;
    end
    check("R6 first os_tick at t+1+X", first, 5);
    wcyc = first; first = -1;
    while (first < 0 && wcyc < 100) begin
      if (bit_tick) first = wcyc;
      else begin @(negedge clk); wcyc++; end
    end
    check("R6 first bit_tick at t+D(X+1)", first, 20);
    n = 0;
    do @(negedge clk); while (!os_tick);
    do begin @(negedge clk); n++; end while (!os_tick);
    check("R2 os spacing X=4", n, 5);

    // R7 and R8: random phase against the model
    for (int seg = 0; seg < 300; seg++) begin
      int act = $urandom_range(0, 3);
      if (act == 0) wr($urandom_range(0, 9));
      else if (act == 1) begin @(posedge clk); #1; sync_mode = $urandom_range(0, 1); end
      else if (act == 2) begin @(posedge clk); #1; high_speed = $urandom_range(0, 1); end
      for (int c = 0; c < int'($urandom_range(20, 150)); c++) begin
        @(posedge clk); #1; rx_pin = $urandom_range(0, 1);
      end
    end

    // R8: steady low line must vote low
    sync_mode = 1'b1; wr(0);
    rx_pin = 1'b0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    check("R8 steady low voted", int'(rx_level), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule